// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs a single Clause-22 management transaction on a shared MDIO line. A one-cycle start strobe captures a read/write flag, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and an 8-bit clock divide setting. The engine derives the MDC clock from the system clock and sends a 32-bit run of ones. It then sends the 32-bit management frame MSB first and raises a one-cycle done pulse when the last bit period ends.

The line is driven through a separate data output and output-enable and is read back through its own input, so it suits an external tristate pad. On a read the engine releases the line for the turnaround and data fields. It reports whether the PHY pulled the line low in the second turnaround bit, together with the 16 data bits it sampled.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, mdc_o is 0, mdio_oe_o is 0, done_o is 0, ack_o is 0 and rdata_o is 0.
- R2: While a transaction runs, MDC has a period of P = div_i + 1 system clocks, with div_i = 0 treated as 1. Each period is low for P - floor(P/2) cycles and then high for floor(P/2) cycles. MDC first rises P - floor(P/2) cycles after the accepting clock edge.
- R3: Bit periods 0 to 31 of every transaction drive a 1 with mdio_oe_o high.
- R4: Bit periods 32 to 63 carry, MSB first, the start pattern 01, then the opcode (10 read, 01 write), then the PHY address, the register address and a turnaround. After that come 16 data bits. A write sends turnaround 10 and wdata_i.
- R5: A write drives the line in all 64 bit periods. A read drives it in bit periods 0 to 45 and releases it (mdio_oe_o low) in periods 46 to 63.
- R6: On a read, ack_o becomes 1 when mdio_i is 0 at the MDC rise of bit period 47, and otherwise 0. rdata_o becomes the 16 values of mdio_i sampled at the MDC rises of periods 48 to 63, first sample in bit 15. Both update in the same cycle as done_o. A write sets ack_o to 0 and leaves rdata_o unchanged.
- R7: mdio_o changes only at the MDC falling edge, so it is stable while MDC is high.
- R8: done_o is high for exactly one cycle, 64·P cycles after the accepting edge.
- R9: A start strobe during a transaction is ignored, and the divider and frame fields stay as captured at the accepting edge.
- R10: When the transaction ends, MDC is low and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | 8 | MDC divide setting, period = div_i + 1 |
| start_i | input | 1 | Begin a transaction when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| mdio_i | input | 1 | Line value read back from the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Line drive value |
| mdio_oe_o | output | 1 | Line drive enable |
| rdata_o | output | 16 | Read data of the last read |
| ack_o | output | 1 | PHY acknowledged the last read |
| done_o | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Every result is due at a fixed offset from the accepting edge. The first MDC rise comes P - floor(P/2) cycles after it and each later rise comes P cycles after the one before. Done, ack and read data arrive together 64·P cycles after the accepting edge, and the line is idle in the next cycle. The bench counts cycles from the start strobe and compares each event against these offsets; a reply model answers from the count of observed MDC falls. Bit values are taken at each MDC rise and then held against every high cycle after it, so both the content and the change point of the line are checked.

// File: rtl/mdio_pkg.sv
// mdio_pkg: frame geometry and frame assembly shared by the engine and its parts.
// Assumes Clause-22 framing: 32 preamble bits followed by a 32-bit frame.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int TA_FIRST   = 46;  // first turnaround bit period
    localparam int TA_SECOND  = 47;  // bit period carrying the PHY acknowledge
    localparam int DATA_FIRST = 48;  // first data bit period

    // Assemble the full 64-bit sequence, first bit in the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              is_read,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad,
        input logic [DATA_W-1:0] wdata
    );
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] dat;
        op  = is_read ? 2'b10 : 2'b01;
        ta  = is_read ? 2'b11 : 2'b10;
        dat = is_read ? {DATA_W{1'b1}} : wdata;
        return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, dat};
    endfunction
endpackage

// File: rtl/mdc_clkgen.sv
// mdc_clkgen: produces MDC and the per-bit rise/end events from the system clock.
// Assumes load_i and run_i are never high together; the divide value is latched on load_i
// and a value of zero is promoted to one so that MDC can toggle.
module mdc_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             end_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] period, hi_len, lo_len, cnt, cnt_nx;

    // Derive bit-period geometry and the two events from the phase counter.
    always_comb begin
        period = CNT_W'(div_q) + CNT_W'(1);
        hi_len = period >> 1;
        lo_len = period - hi_len;
        cnt_nx = cnt + CNT_W'(1);
        end_o  = run_i && (cnt_nx == period);
        rise_o = run_i && !end_o && (cnt_nx == lo_len);
    end

    // Capture the divide setting when a transaction is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)           div_q <= DIV_W'(1);
        else if (load_i)      div_q <= (div_i == '0) ? DIV_W'(1) : div_i;
    end

    // Phase counter within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) cnt <= '0;
        else if (run_i)       cnt <= end_o ? '0 : cnt_nx;
        else                  cnt <= '0;
    end

    // MDC: low phase first, high phase second, low whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)      mdc_o <= 1'b0;
        else if (run_i && !end_o)  mdc_o <= (cnt_nx >= lo_len);
        else                       mdc_o <= 1'b0;
    end

    // R2: the rise event finds MDC low and leaves it high.
    a_r2_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !mdc_o);
    a_r2_rise_to_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> mdc_o);
    // R2: every bit period ends with MDC low.
    a_r2_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> !mdc_o);
endmodule

// File: rtl/mdio_shifter.sv
// mdio_shifter: shifts the outgoing sequence, controls the drive enable and
// captures the acknowledge and read data. Assumes shift_i marks each MDC fall,
// sample_i each MDC rise, and bit_idx_i the current bit period.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  is_read_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  shift_i,
    input  logic                  last_i,
    input  logic                  sample_i,
    input  logic [IDX_W-1:0]      bit_idx_i,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe_o,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  ack_o
);
    logic [FRAME_BITS-1:0] tx_q;
    logic                  rd_q;
    logic                  ack_s;
    logic [DATA_W-1:0]     rx_q;
    logic [IDX_W-1:0]      next_idx;

    assign mdio_o   = tx_q[FRAME_BITS-1];
    assign next_idx = bit_idx_i + IDX_W'(1);

    // Outgoing shift register and captured direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rd_q <= 1'b0;
        end else if (load_i) begin
            tx_q <= frame_i;
            rd_q <= is_read_i;
        end else if (shift_i) begin
            tx_q <= tx_q << 1;
        end
    end

    // Drive enable: on from the start, off for read turnaround/data and at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)        mdio_oe_o <= 1'b0;
        else if (load_i)   mdio_oe_o <= 1'b1;
        else if (shift_i)  mdio_oe_o <= !last_i && (!rd_q || (next_idx < IDX_W'(TA_FIRST)));
    end

    // Sample the acknowledge and data bits at MDC rises of a read.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            ack_s <= 1'b0;
            rx_q  <= '0;
        end else if (sample_i && rd_q) begin
            if (bit_idx_i == IDX_W'(TA_SECOND))  ack_s <= !mdio_i;
            if (bit_idx_i >= IDX_W'(DATA_FIRST)) rx_q  <= {rx_q[DATA_W-2:0], mdio_i};
        end
    end

    // Commit results with the final bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            ack_o   <= 1'b0;
        end else if (shift_i && last_i) begin
            ack_o <= rd_q && ack_s;
            if (rd_q) rdata_o <= rx_q;
        end
    end

    // R7: the driven value holds between shift events.
    a_r7_hold_between_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe_o && !$past(shift_i) && !$past(load_i)) |-> $stable(mdio_o));
    // R6: results change only at the end of a transaction.
    a_r6_commit_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_o != $past(ack_o)) || (rdata_o != $past(rdata_o))) |-> $past(shift_i && last_i));
endmodule

// File: rtl/mdio_frame_engine.sv
// mdio_frame_engine: accepts one transaction request, runs 64 bit periods on
// MDC/MDIO and pulses done. Assumes the pad merges mdio_o/mdio_oe_o and returns
// the line level on mdio_i.
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mdio_i,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_o,
    output logic              done_o
);
    logic             busy;
    logic [IDX_W-1:0] bit_idx;
    logic             accept, rise_evt, end_evt, last_bit;

    assign accept   = start_i && !busy;
    assign last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));

    mdc_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .run_i  (busy),
        .div_i  (div_i),
        .mdc_o  (mdc_o),
        .rise_o (rise_evt),
        .end_o  (end_evt)
    );

    mdio_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .is_read_i (rd_i),
        .frame_i   (build_frame(rd_i, phy_addr_i, reg_addr_i, wdata_i)),
        .shift_i   (end_evt),
        .last_i    (last_bit),
        .sample_i  (rise_evt),
        .bit_idx_i (bit_idx),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .rdata_o   (rdata_o),
        .ack_o     (ack_o)
    );

    // Transaction sequencer: busy flag, bit period index and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                bit_idx <= '0;
            end else if (busy && end_evt) begin
                if (last_bit) begin
                    busy   <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    bit_idx <= bit_idx + IDX_W'(1);
                end
            end
        end
    end

    // R8: done lasts a single cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: at done the clock is low and the line released.
    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mdc_o && !mdio_oe_o));
    // R9: within a bit period the index holds, whatever start does.
    a_r9_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !end_evt) |=> (busy && $stable(bit_idx)));
    // R7: a change of the driven value during a transaction comes with MDC low.
    a_r7_change_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (mdio_o != $past(mdio_o))) |-> !mdc_o);
    // R2: MDC only toggles high during a transaction.
    a_r2_mdc_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> busy);
endmodule

// File: tb/sim_mdio_frame_engine.sv
module sim_mdio_frame_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_i = 8'd1;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        mdio_i = 1'b1;
    logic        mdc_o, mdio_o, mdio_oe_o, ack_o, done_o;
    logic [15:0] rdata_o;

    int tests = 0;
    int fails = 0;
    logic [15:0] prev_rdata = 16'h0;

    always #2 clk = ~clk;

    mdio_frame_engine u0 (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .mdio_i(mdio_i), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
        .rdata_o(rdata_o), .ack_o(ack_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [7:0] dv,
                             input bit pack, input logic [15:0] pdat, input bit inject);
        int p, lo, n, bitcnt, rises, last_rise, bad_per, done_n, first_rise;
        int pre_bad, frm_bad, oe_bad;
        bit prevmdc, hold_bad;
        logic held;
        logic [63:0] exp_f;
        logic cap_v [64];
        logic cap_oe [64];
        p  = (dv == 0) ? 2 : int'(dv) + 1;
        lo = p - p / 2;
        exp_f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
        @(negedge clk);
        rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; div_i = dv;
        start_i = 1'b1; mdio_i = 1'b1;
        n = 0; bitcnt = 0; rises = 0; last_rise = 0; bad_per = 0; done_n = -1;
        first_rise = -1; prevmdc = 1'b0; hold_bad = 1'b0; held = 1'b0;
        while (done_n < 0 && n < 64 * 257 + 20) begin
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (inject && n == 3 * p + 1) begin
                start_i = 1'b1; rd_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra;
                wdata_i = ~wd; div_i = dv + 8'd3;
            end
            if (!prevmdc && mdc_o) begin
                if (rises < 64) begin
                    cap_v[rises]  = mdio_o;
                    cap_oe[rises] = mdio_oe_o;
                end
                if (rises == 0) first_rise = n;
                else if (n - last_rise != p) bad_per++;
                last_rise = n;
                rises++;
                held = mdio_o;
            end
            if (mdc_o && mdio_o !== held) hold_bad = 1'b1;
            if (prevmdc && !mdc_o) bitcnt++;
            prevmdc = mdc_o;
            if (done_o) done_n = n;
            if (mdio_oe_o)                         mdio_i = mdio_o;
            else if (bitcnt == 47)                 mdio_i = pack ? 1'b0 : 1'b1;
            else if (bitcnt >= 48 && bitcnt < 64 && pack) mdio_i = pdat[63 - bitcnt];
            else                                   mdio_i = 1'b1;
        end
        if (done_n < 0) begin
            check(1'b0, "R8 watchdog: no done", n, 64 * p + 1);
            return;
        end
        // R8: done timing
        check(done_n == 64 * p + 1, "R8 done cycle", done_n, 64 * p + 1);
        // R2: first rise and period
        check(first_rise == lo + 1, "R2 first MDC rise", first_rise, lo + 1);
        check(bad_per == 0 && rises == 64, "R2 MDC period/rise count", rises, 64);
        // R7: stable while high
        check(!hold_bad, "R7 line stable while MDC high", hold_bad, 0);
        pre_bad = 0; frm_bad = 0; oe_bad = 0;
        for (int i = 0; i < 64; i++) begin
            logic eoe;
            eoe = rd ? (i < 46) : 1'b1;
            if (cap_oe[i] !== eoe) oe_bad++;
            else if (eoe && cap_v[i] !== exp_f[63 - i]) begin
                if (i < 32) pre_bad++; else frm_bad++;
            end
        end
        check(pre_bad == 0, "R3 preamble ones", pre_bad, 0);
        check(frm_bad == 0, "R4 frame fields", frm_bad, 0);
        check(oe_bad == 0, "R5 drive enable pattern", oe_bad, 0);
        if (inject) check(done_n == 64 * p + 1 && frm_bad == 0 && bad_per == 0,
                          "R9 start ignored while busy", done_n, 64 * p + 1);
        if (rd) begin
            logic [15:0] er;
            er = pack ? pdat : 16'hFFFF;
            check(ack_o == pack, "R6 read ack", ack_o, pack);
            check(rdata_o == er, "R6 read data", rdata_o, er);
            prev_rdata = er;
        end else begin
            check(ack_o == 1'b0, "R6 write clears ack", ack_o, 0);
            check(rdata_o == prev_rdata, "R6 write keeps rdata", rdata_o, prev_rdata);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        check(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R10 idle after done",
              {mdc_o, mdio_oe_o}, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mdc_o == 0 && mdio_oe_o == 0 && done_o == 0, "R1 reset outputs",
              {mdc_o, mdio_oe_o, done_o}, 0);
        check(ack_o == 0 && rdata_o == 0, "R1 reset results", rdata_o, 0);
        // Directed corners
        run_frame(1'b0, 5'h01, 5'h00, 16'hA55A, 8'd1,  1'b1, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h1F, 16'h0000, 8'd0,  1'b1, 16'h8001, 1'b0);
        run_frame(1'b1, 5'h0A, 5'h15, 16'h0000, 8'd4,  1'b0, 16'h1234, 1'b0);
        run_frame(1'b0, 5'h10, 5'h02, 16'hFFFF, 8'd2,  1'b0, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h05, 5'h0C, 16'h0000, 8'd3,  1'b1, 16'hC3E7, 1'b1);
        run_frame(1'b0, 5'h00, 5'h1E, 16'h0001, 8'd255, 1'b1, 16'h0000, 1'b0);
        // Random transactions
        for (int k = 0; k < 6; k++) begin
            logic [7:0] dv;
            dv = 8'($urandom_range(1, 20));
            run_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), dv,
                      1'($urandom), 16'($urandom), 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule